// File: doc/BRIEF.md
# Queue-Fill Driven Lookup Engine Selector

This controller watches how full the packet queue in front of a lookup stage is, and decides when to replace the active lookup engine with a faster or a slower one. Engine codes are 0 (slowest, least power), 1 (middle) and 2 (fastest, most power). The thresholds form a ladder. A rising crossing of any rung asks for one step faster. Each step is separate, so a fill that jumps past several rungs is served one engine at a time.

The controller steps back down only when the queue has drained below the lowest rung and the energy saved is worth a swap. It estimates the saving by adding up, each cycle, the difference in power weight between the active engine and the next slower one. It permits the step down once that total is larger than a fixed reconfiguration cost.

Each request starts a fixed reconfiguration window. The window length depends on the target engine. No lookups run during the window, and no other request is issued until it ends. A per-engine occupancy ceiling can also hold back a step down. It limits how much queued data a slower engine would inherit, and so bounds queuing delay.

Top module: `reconfig_ctrl`

## Requirements
- R1: A rising crossing of any threshold (defaults 50000, 200000 and 500000 bytes; occupancy counts as above a threshold when it is greater than or equal to it) requests the engine one code faster: `tgt_o` = `active_o` + 1.
- R2: Occupancy held above a threshold produces exactly one request for that crossing. When engine 2 is already active, a crossing produces no request.
- R3: Crossings that occur while a reconfiguration is running are remembered. They are served one step at a time once the controller is idle, the first in the cycle after `busy_o` falls, until engine 2 is reached.
- R4: A step down (`tgt_o` = `active_o` − 1) is requested only while occupancy is below the lowest threshold.
- R5: In each idle cycle with `active_o` > 0 and occupancy below the lowest threshold, the gain total grows by weight[active] − weight[active−1], or by 0 if that difference is negative. The step down is issued on the first clock edge at which the total already exceeds COST (default 2000). The total is cleared at every request and stays at zero while busy.
- R6: The gain total saturates at its all-ones value instead of wrapping.
- R7: A step down also requires occupancy ≤ `jit_lim_i[active−1]`, the ceiling of the slower engine.
- R8: `req_o` is a one-cycle pulse. `busy_o` rises together with it, and no request is issued while `busy_o` is high.
- R9: `busy_o` stays high for ceil(reconfiguration time / clock period) cycles of the target engine. The defaults are 100 ns, 3200 ns and 100 ns at 8 ns, which gives 13, 400 and 13 cycles. `active_o` takes the target value in the cycle that `busy_o` falls and changes at no other time.
- R10: After reset, `req_o` = 0, `busy_o` = 0, `tgt_o` = 0 and `active_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| occ_i | input | OCC_W | Queue occupancy in bytes |
| pw_i | input | 3×PW_W | Power weight per engine, index = engine code |
| jit_lim_i | input | 3×OCC_W | Per-engine occupancy ceiling for entering that engine downward |
| req_o | output | 1 | One-cycle reconfiguration request |
| tgt_o | output | 2 | Engine code requested |
| busy_o | output | 1 | Reconfiguration in progress |
| active_o | output | 2 | Engine code in service |

## Verification
The bench keeps the default thresholds, cost and reconfiguration times, so the windows are exactly 13 and 400 cycles at the 8 ns clock. It narrows the gain total and the weights to 12 bits. With weights 30, 82 and 1020, the step down from engine 2 needs 3 accumulating cycles and the step down from engine 1 needs 39. Saturation of the gain total is reached within a hundred cycles, and a wrapping total would lose the permission it had earned.

// File: rtl/reconfig_ctrl.sv
module reconfig_ctrl #(
  parameter int OCC_W    = 24,
  parameter int PW_W     = 16,
  parameter int ACC_W    = 24,
  parameter int THR0     = 50000,
  parameter int THR1     = 200000,
  parameter int THR2     = 500000,
  parameter int COST     = 2000,
  parameter int CLK_NS   = 8,
  parameter int RCFG_NS0 = 100,
  parameter int RCFG_NS1 = 3200,
  parameter int RCFG_NS2 = 100
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [OCC_W-1:0]         occ_i,
  input  logic [2:0][PW_W-1:0]     pw_i,
  input  logic [2:0][OCC_W-1:0]    jit_lim_i,
  output logic                     req_o,
  output logic [1:0]               tgt_o,
  output logic                     busy_o,
  output logic [1:0]               active_o
);

  localparam int CYC0    = (RCFG_NS0 + CLK_NS - 1) / CLK_NS;
  localparam int CYC1    = (RCFG_NS1 + CLK_NS - 1) / CLK_NS;
  localparam int CYC2    = (RCFG_NS2 + CLK_NS - 1) / CLK_NS;
  localparam int CYC_A   = (CYC0 > CYC1) ? CYC0 : CYC1;
  localparam int CYC_MAX = (CYC_A > CYC2) ? CYC_A : CYC2;
  localparam int CNT_W   = $clog2(CYC_MAX + 1);

  localparam logic [OCC_W-1:0] T0      = OCC_W'(THR0);
  localparam logic [OCC_W-1:0] T1      = OCC_W'(THR1);
  localparam logic [OCC_W-1:0] T2      = OCC_W'(THR2);
  localparam logic [ACC_W-1:0] COST_V  = ACC_W'(COST);
  localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};
  localparam logic [1:0]       TOP     = 2'd2;

  logic [2:0]       above, above_q, rise;
  logic [2:0]       pend_q, want, pend_nxt;
  logic             busy_q, req_q;
  logic [1:0]       act_q, tgt_q, nxt_tgt;
  logic [CNT_W-1:0] cnt_q, nxt_cyc;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic [PW_W-1:0]  pw_hi, pw_lo, delta;
  logic [OCC_W-1:0] jit_dn;
  logic             low, can_up, can_dn, issue;

  assign above = {occ_i >= T2, occ_i >= T1, occ_i >= T0};
  assign rise  = above & ~above_q;
  assign want  = pend_q + {2'b0, rise[0]} + {2'b0, rise[1]} + {2'b0, rise[2]};
  assign low   = occ_i < T0;

  always_comb begin
    pw_hi  = '0;
    pw_lo  = '0;
    jit_dn = '0;
    case (act_q)
      2'd1: begin pw_hi = pw_i[1]; pw_lo = pw_i[0]; jit_dn = jit_lim_i[0]; end
      2'd2: begin pw_hi = pw_i[2]; pw_lo = pw_i[1]; jit_dn = jit_lim_i[1]; end
      default: ;
    endcase
  end

  assign delta = (pw_hi > pw_lo) ? (pw_hi - pw_lo) : '0;
  assign sum   = {1'b0, acc_q} + {1'b0, ACC_W'(delta)};

  assign can_up  = !busy_q && (want != 3'd0) && (act_q != TOP);
  assign can_dn  = !busy_q && (want == 3'd0) && (act_q != 2'd0) && low &&
                   (occ_i <= jit_dn) && (acc_q > COST_V);
  assign issue   = can_up || can_dn;
  assign nxt_tgt = can_up ? act_q + 2'd1 : act_q - 2'd1;

  always_comb begin
    case (nxt_tgt)
      2'd0:    nxt_cyc = CNT_W'(CYC0 - 1);
      2'd1:    nxt_cyc = CNT_W'(CYC1 - 1);
      default: nxt_cyc = CNT_W'(CYC2 - 1);
    endcase
  end

  always_comb begin
    if (busy_q)      pend_nxt = want;
    else if (can_up) pend_nxt = want - 3'd1;
    else             pend_nxt = '0;
    if (pend_nxt > 3'd3) pend_nxt = 3'd3;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      above_q <= '0;
      pend_q  <= '0;
      busy_q  <= 1'b0;
      req_q   <= 1'b0;
      act_q   <= '0;
      tgt_q   <= '0;
      cnt_q   <= '0;
      acc_q   <= '0;
    end else begin
      above_q <= above;
      pend_q  <= pend_nxt;
      req_q   <= issue;
      if (issue) begin
        busy_q <= 1'b1;
        tgt_q  <= nxt_tgt;
        cnt_q  <= nxt_cyc;
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          act_q  <= tgt_q;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      if (issue || busy_q)
        acc_q <= '0;
      else if (act_q != 2'd0 && low)
        acc_q <= sum[ACC_W] ? ACC_MAX : sum[ACC_W-1:0];
    end
  end

  assign req_o    = req_q;
  assign tgt_o    = tgt_q;
  assign busy_o   = busy_q;
  assign active_o = act_q;

  a_r8_no_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> !req_o);
  a_r8_busy_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> busy_o);
  a_r9_active_moves_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_o) |-> $fell(busy_o));
  a_r1_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (tgt_o == active_o + 2'd1) || (tgt_o + 2'd1 == active_o));
  a_r5_gain_before_down: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && (tgt_o < active_o) |-> $past(acc_q) > COST_V);
  a_r4_down_only_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && (tgt_o < active_o) |-> $past(occ_i) < T0);
  a_r6_acc_holds_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc_q) == ACC_MAX) && !$past(busy_q) && !$past(issue) |-> acc_q == ACC_MAX);

endmodule

// File: tb/reconfig_ctrl_tb.sv
module reconfig_ctrl_tb;
  localparam int OCC_W = 24;
  localparam int PW_W  = 12;
  localparam int ACC_W = 12;
  localparam int COST  = 2000;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [OCC_W-1:0]      occ = '0;
  logic [2:0][PW_W-1:0]  pw;
  logic [2:0][OCC_W-1:0] jit;
  logic                  req, busy;
  logic [1:0]            tgt, act;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  reconfig_ctrl #(.OCC_W(OCC_W), .PW_W(PW_W), .ACC_W(ACC_W), .COST(COST)) u_dut (
    .clk(clk), .rst_n(rst_n), .occ_i(occ), .pw_i(pw), .jit_lim_i(jit),
    .req_o(req), .tgt_o(tgt), .busy_o(busy), .active_o(act));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string rq, input int actual, input int expected);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, actual, expected);
    end
  endtask

  function automatic int gain_wait(input int d);
    return (COST + d) / d + 1;
  endfunction

  task automatic expect_req(input int exp_tgt, input string rq);
    chk(req == 1'b1, {rq, " request"}, int'(req), 1);
    chk(tgt == 2'(exp_tgt), {rq, " target"}, int'(tgt), exp_tgt);
  endtask

  task automatic wait_busy(input int exp_len, input int exp_act);
    int n = 0;
    bit extra = 1'b0;
    while (busy && n < 2000) begin
      n++;
      if (n > 1 && req) extra = 1'b1;
      step(1);
    end
    chk(n == exp_len, "R9 busy length", n, exp_len);
    chk(!extra, "R8 request while busy", int'(extra), 0);
    chk(act == 2'(exp_act), "R9 active after window", int'(act), exp_act);
  endtask

  task automatic no_req(input int cycles, input string rq);
    bit seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      step(1);
      if (req) seen = 1'b1;
    end
    chk(!seen, rq, int'(seen), 0);
  endtask

  task automatic count_to_req(output int n);
    n = 0;
    do begin
      step(1);
      n++;
    end while (!req && n < 5000);
  endtask

  task automatic s_reset;
    step(1);
    chk(req == 1'b0 && busy == 1'b0, "R10 req/busy after reset", int'({req, busy}), 0);
    chk(act == 2'd0 && tgt == 2'd0, "R10 engine after reset", int'({act, tgt}), 0);
  endtask

  task automatic s_up_ladder;
    occ = 24'd60000;
    step(1);
    expect_req(1, "R1 first rung");
    wait_busy(400, 1);
    no_req(40, "R2 level held gives one request");
    occ = 24'd250000;
    step(1);
    expect_req(2, "R1 second rung");
    wait_busy(13, 2);
    occ = 24'd600000;
    no_req(30, "R2 no request at fastest engine");
  endtask

  task automatic s_hold_mid;
    occ = 24'd100000;
    no_req(60, "R4 no step down above lowest rung");
  endtask

  task automatic s_gain_down;
    int n;
    occ = 24'd10000;
    count_to_req(n);
    chk(n == gain_wait(938), "R5 gain window 2 to 1", n, gain_wait(938));
    expect_req(1, "R4 step down to 1");
    wait_busy(400, 1);
    count_to_req(n);
    chk(n == gain_wait(52), "R5 gain window 1 to 0", n, gain_wait(52));
    expect_req(0, "R4 step down to 0");
    wait_busy(13, 0);
  endtask

  task automatic s_pending;
    occ = 24'd600000;
    step(1);
    expect_req(1, "R3 jump past all rungs");
    wait_busy(400, 1);
    step(1);
    expect_req(2, "R3 remembered crossing served");
    wait_busy(13, 2);
    no_req(30, "R3 remaining steps dropped at fastest");
  endtask

  task automatic s_jitter_sat;
    int n;
    jit[0] = 24'd5000;
    occ = 24'd10000;
    count_to_req(n);
    chk(n == gain_wait(938), "R7 ceiling of engine 1 not limiting", n, gain_wait(938));
    expect_req(1, "R7 step to 1");
    wait_busy(400, 1);
    no_req(100, "R7 ceiling blocks step down");
    occ = 24'd4000;
    step(1);
    expect_req(0, "R6 saturated gain releases at once");
    wait_busy(13, 0);
  endtask

  initial begin
    pw[0] = 12'd30;
    pw[1] = 12'd82;
    pw[2] = 12'd1020;
    jit[0] = '1;
    jit[1] = '1;
    jit[2] = '1;
    step(3);
    rst_n = 1'b1;
    s_reset();
    s_up_ladder();
    s_hold_mid();
    s_gain_down();
    s_pending();
    s_jitter_sat();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule